// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Generator

This block produces a derived clock whose high time, or whose rising-edge position, can be placed in steps of one thirty-second of a reference period. It runs on a fast system clock. A free-running slot counter divides each reference period into equal slots. A registered comparator stage turns the current slot into the output level.

An 8-bit width code picks the slot count N. The code has two levels. The top two bits choose a quarter-period range. One of two 3-bit fine fields then refines the value within that range. The coarse field decides which fine field is used.

Two mode inputs are also sampled. One chooses between a pulse-width output and a delayed-edge output. The other chooses a single-rate or double-rate pattern, and it only matters for the delayed-edge output.

All three settings are copied into shadow registers only when the slot counter wraps to the start of a period. Each period is therefore generated from a single, consistent setting.

Top module: `duty_clkgen`

## Requirements
- R1: N is computed as coarse*8 + fine + 1, where coarse is `cfg_duty[7:6]`. If the result would be 32 (coarse 3, fine 7), it is clamped to 31. N is always between 1 and 31.
- R2: For coarse 0 or 1, fine is taken from `cfg_duty[2:0]` and bits [5:3] have no effect on the output. For coarse 2 or 3, fine is taken from `cfg_duty[5:3]` and bits [2:0] have no effect.
- R3: With `cfg_mode`=1 (pulse-width mode), the output is high in slots 0 to N-1 and low in the remaining slots of every 32-slot period. In this mode `cfg_rate` has no effect.
- R4: With `cfg_mode`=0 and `cfg_rate`=0 (delayed edge, single rate), the output is high in slot s exactly when (s - N) mod 32 < 16. It rises at slot N.
- R5: With `cfg_mode`=0 and `cfg_rate`=1 (double rate), let H = max(floor(N/2), 1). The output is high in slot s exactly when ((s mod 16) - H) mod 16 < 8.
- R6: The settings are sampled only on the clock edge where the slot index goes from 31 to 0. A change at any other time affects nothing until the next period starts.
- R7: The slot index advances by one per clock and wraps from 31 to 0. The output is registered, so the level driven after the edge that processes slot s is the level for slot s.
- R8: Asserting `rst_n` low forces the output low at once. Once `rst_n` is high again, two clock edges pass before the edge that processes slot 0. The first period then uses the reset settings: delayed edge, single rate, code 01_000_111 (N=16, a 50% pattern).
- R9: Code 01_xxx_100 in pulse-width mode gives 13 high slots per period (40.625%). Code 11_110_xxx in delayed-edge single-rate mode rises at slot 31 (a delay of 31/32 of the period).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system clock; one period of it is one slot |
| rst_n | input | 1 | Active-low reset; asserts asynchronously, releases synchronously |
| cfg_duty | input | 8 | Two-level width code: coarse [7:6], upper fine [5:3], lower fine [2:0] |
| cfg_mode | input | 1 | 0 = delayed-edge output, 1 = pulse-width output |
| cfg_rate | input | 1 | 0 = single rate, 1 = double rate (delayed-edge mode only) |
| clk_out | output | 1 | Generated clock, registered |

## Verification
The bench uses the default parameters: a 2-bit coarse field and 3-bit fine fields, which give 32 slots and an 8-bit code. With these widths, all 256 code values, every slot position and both fine-field selections can be reached within a few thousand cycles. This includes the clamp at code 11_111_xxx and the double-rate floor at N=1. The reference model in the bench is written for these widths, so building the bench with other parameter values would need a matching model.

// File: rtl/duty_clkgen_pkg.sv
package duty_clkgen_pkg;
  typedef enum logic {
    MODE_DELAY = 1'b0,
    MODE_DUTY  = 1'b1
  } gen_mode_e;

  typedef enum logic {
    RATE_1X = 1'b0,
    RATE_2X = 1'b1
  } gen_rate_e;
endpackage

// File: rtl/duty_rst_sync.sv
module duty_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_i_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_i_n = sync_q[STAGES-1];

  // R8: internal reset only deasserts after the external reset was already high
  a_r8_release_sync: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_i_n) |-> $past(rst_n));
endmodule

// File: rtl/duty_slot_ctr.sv
module duty_slot_ctr #(
  parameter int SLOT_W = 5
) (
  input  logic              clk,
  input  logic              rst_i_n,
  output logic [SLOT_W-1:0] slot,
  output logic              wrap
);
  localparam logic [SLOT_W-1:0] LAST = {SLOT_W{1'b1}};

  logic [SLOT_W-1:0] slot_d;

  always_comb begin
    wrap   = (slot == LAST);
    slot_d = slot + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) slot <= '0;
    else          slot <= slot_d;
  end

  a_r7_slot_step: assert property (@(posedge clk) disable iff (!rst_i_n)
    (slot != LAST) |=> (slot == $past(slot) + SLOT_W'(1)));
  a_r7_slot_wrap: assert property (@(posedge clk) disable iff (!rst_i_n)
    (slot == LAST) |=> (slot == '0));
endmodule

// File: rtl/duty_cfg_shadow.sv
module duty_cfg_shadow
  import duty_clkgen_pkg::*;
#(
  parameter int COARSE_W = 2,
  parameter int FINE_W   = 3,
  localparam int SLOT_W  = COARSE_W + FINE_W,
  localparam int DUTY_W  = COARSE_W + 2 * FINE_W
) (
  input  logic              clk,
  input  logic              rst_i_n,
  input  logic              load_en,
  input  logic [DUTY_W-1:0] cfg_duty,
  input  logic              cfg_mode,
  input  logic              cfg_rate,
  output logic [SLOT_W-1:0] n_slots,
  output gen_mode_e         mode_q,
  output gen_rate_e         rate_q
);
  localparam logic [COARSE_W-1:0] RST_COARSE = COARSE_W'((1 << (COARSE_W - 1)) - 1);
  localparam logic [DUTY_W-1:0]   RST_DUTY   = {RST_COARSE, {FINE_W{1'b0}}, {FINE_W{1'b1}}};
  localparam logic [SLOT_W:0]     N_MAX      = (SLOT_W+1)'((1 << SLOT_W) - 1);

  logic [DUTY_W-1:0]   duty_q, duty_d;
  gen_mode_e           mode_d;
  gen_rate_e           rate_d;
  logic [COARSE_W-1:0] coarse;
  logic [FINE_W-1:0]   fine;
  logic [SLOT_W:0]     n_full;

  // next-state: hold unless the period boundary is reached
  always_comb begin
    duty_d = duty_q;
    mode_d = mode_q;
    rate_d = rate_q;
    if (load_en) begin
      duty_d = cfg_duty;
      mode_d = gen_mode_e'(cfg_mode);
      rate_d = gen_rate_e'(cfg_rate);
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      duty_q <= RST_DUTY;
      mode_q <= MODE_DELAY;
      rate_q <= RATE_1X;
    end else begin
      duty_q <= duty_d;
      mode_q <= mode_d;
      rate_q <= rate_d;
    end
  end

  // two-level decode: coarse MSB selects which fine field counts
  always_comb begin
    coarse = duty_q[DUTY_W-1 -: COARSE_W];
    if (coarse[COARSE_W-1]) fine = duty_q[2*FINE_W-1 -: FINE_W];
    else                    fine = duty_q[FINE_W-1:0];
    n_full = {1'b0, coarse, fine} + (SLOT_W+1)'(1);
    if (n_full > N_MAX) n_slots = N_MAX[SLOT_W-1:0];
    else                n_slots = n_full[SLOT_W-1:0];
  end

  always_comb begin
    if (rst_i_n) begin
      a_r1_n_range: assert (n_slots != '0);
    end
  end

  a_r6_shadow_hold: assert property (@(posedge clk) disable iff (!rst_i_n)
    !load_en |=> ($stable(duty_q) && $stable(mode_q) && $stable(rate_q)));
endmodule

// File: rtl/duty_wave_gen.sv
module duty_wave_gen
  import duty_clkgen_pkg::*;
#(
  parameter int SLOT_W = 5,
  localparam int HALF_W = SLOT_W - 1
) (
  input  logic              clk,
  input  logic              rst_i_n,
  input  logic [SLOT_W-1:0] slot,
  input  logic [SLOT_W-1:0] n_slots,
  input  gen_mode_e         mode,
  input  gen_rate_e         rate,
  output logic              clk_out
);
  logic [SLOT_W-1:0] diff_full;
  logic [HALF_W-1:0] n_half;
  logic [HALF_W-1:0] diff_half;
  logic              duty_hi, delay1_hi, delay2_hi, out_d;

  always_comb begin
    duty_hi   = (slot < n_slots);
    diff_full = slot - n_slots;
    delay1_hi = ~diff_full[SLOT_W-1];
    n_half    = n_slots[SLOT_W-1:1];
    if (n_half == '0) n_half = HALF_W'(1);
    diff_half = slot[HALF_W-1:0] - n_half;
    delay2_hi = ~diff_half[HALF_W-1];
    if (mode == MODE_DUTY)   out_d = duty_hi;
    else if (rate == RATE_2X) out_d = delay2_hi;
    else                      out_d = delay1_hi;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) clk_out <= 1'b0;
    else          clk_out <= out_d;
  end

  a_r3_duty_head: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode == MODE_DUTY && slot == '0) |=> clk_out);
  a_r3_duty_tail: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode == MODE_DUTY && slot == {SLOT_W{1'b1}}) |=> !clk_out);
  a_r4_delay_rise: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode == MODE_DELAY && rate == RATE_1X && slot == n_slots) |=> clk_out);
  a_r5_half_rise: assert property (@(posedge clk) disable iff (!rst_i_n)
    (mode == MODE_DELAY && rate == RATE_2X && slot[HALF_W-1:0] == n_half) |=> clk_out);
endmodule

// File: rtl/duty_clkgen.sv
module duty_clkgen
  import duty_clkgen_pkg::*;
#(
  parameter int COARSE_W = 2,
  parameter int FINE_W   = 3,
  localparam int SLOT_W  = COARSE_W + FINE_W,
  localparam int DUTY_W  = COARSE_W + 2 * FINE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DUTY_W-1:0] cfg_duty,
  input  logic              cfg_mode,
  input  logic              cfg_rate,
  output logic              clk_out
);
  logic              rst_i_n;
  logic [SLOT_W-1:0] slot;
  logic              wrap;
  logic [SLOT_W-1:0] n_slots;
  gen_mode_e         mode_q;
  gen_rate_e         rate_q;

  duty_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_i_n(rst_i_n)
  );

  duty_slot_ctr #(.SLOT_W(SLOT_W)) u_ctr (
    .clk(clk), .rst_i_n(rst_i_n), .slot(slot), .wrap(wrap)
  );

  duty_cfg_shadow #(.COARSE_W(COARSE_W), .FINE_W(FINE_W)) u_cfg (
    .clk(clk), .rst_i_n(rst_i_n), .load_en(wrap),
    .cfg_duty(cfg_duty), .cfg_mode(cfg_mode), .cfg_rate(cfg_rate),
    .n_slots(n_slots), .mode_q(mode_q), .rate_q(rate_q)
  );

  duty_wave_gen #(.SLOT_W(SLOT_W)) u_wave (
    .clk(clk), .rst_i_n(rst_i_n), .slot(slot), .n_slots(n_slots),
    .mode(mode_q), .rate(rate_q), .clk_out(clk_out)
  );

  a_r8_out_low_in_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_i_n |-> !clk_out);
endmodule

// File: tb/test_duty_clkgen.sv
module test_duty_clkgen;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] cfg_duty;
  logic       cfg_mode;
  logic       cfg_rate;
  logic       clk_out;

  int errors = 0;
  int checks = 0;
  int slot_m;
  logic [7:0] sh_duty;
  logic       sh_mode, sh_rate;

  always #4 clk = ~clk;

  duty_clkgen i_duty_clkgen (
    .clk(clk), .rst_n(rst_n), .cfg_duty(cfg_duty),
    .cfg_mode(cfg_mode), .cfg_rate(cfg_rate), .clk_out(clk_out)
  );

  function automatic logic model(int s, logic [7:0] d, logic m, logic r);
    int c, f, n, h;
    c = int'(d[7:6]);
    f = (c >= 2) ? int'(d[5:3]) : int'(d[2:0]);
    n = c * 8 + f + 1;
    if (n > 31) n = 31;
    if (m) return s < n;
    if (!r) return ((s - n + 32) % 32) < 16;
    h = n / 2;
    if (h < 1) h = 1;
    return (((s % 16) - h + 16) % 16) < 8;
  endfunction

  task automatic check(logic act, logic exp, string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s slot=%0d actual=%b expected=%b", tag, slot_m, act, exp);
    end
  endtask

  task automatic step(string tag);
    logic e;
    string t;
    int s;
    @(posedge clk);
    s = slot_m;
    e = model(slot_m, sh_duty, sh_mode, sh_rate);
    t = tag;
    if (t == "") t = sh_mode ? "R3" : (sh_rate ? "R5" : "R4");
    if (slot_m == 31) begin
      sh_duty = cfg_duty; sh_mode = cfg_mode; sh_rate = cfg_rate;
    end
    slot_m = (slot_m + 1) % 32;
    #2;
    checks++;
    if (clk_out !== e) begin
      errors++;
      $display("FAIL %s slot=%0d actual=%b expected=%b", t, s, clk_out, e);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    #1;
    check(clk_out, 1'b0, "R8");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #2;
    check(clk_out, 1'b0, "R8");
    slot_m = 0;
    sh_duty = 8'b01_000_111; sh_mode = 1'b0; sh_rate = 1'b0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic set_cfg(logic [7:0] d, logic m, logic r);
    cfg_duty = d; cfg_mode = m; cfg_rate = r;
  endtask

  task automatic align();
    while (slot_m != 0) step("");
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL R7 watchdog expired actual=hang expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int hi_cnt;
    void'($urandom(32'd1357));
    rst_n = 1'b0;
    set_cfg(8'b00_000_000, 1'b1, 1'b0);
    do_reset();
    // R8: first period follows reset defaults even though inputs differ
    run(32, "R8");
    // R9: 40.625% pulse width, upper fine field is junk
    set_cfg(8'b01_101_100, 1'b1, 1'b0);
    run(32, "R9");
    hi_cnt = 0;
    for (int i = 0; i < 32; i++) begin step("R9"); hi_cnt += int'(clk_out); end
    check(hi_cnt == 13, 1'b1, "R9");
    // R9: delay of 31/32, lower fine field junk
    set_cfg(8'b11_110_011, 1'b0, 1'b0);
    align(); run(64, "R9");
    // R2: ignored fine fields
    set_cfg(8'b10_010_111, 1'b1, 1'b0); align(); run(64, "R2");
    set_cfg(8'b10_010_000, 1'b1, 1'b0); align(); run(64, "R2");
    set_cfg(8'b00_111_011, 1'b0, 1'b0); align(); run(64, "R2");
    // R1: clamp to 31
    set_cfg(8'b11_111_000, 1'b1, 1'b0); align(); run(64, "R1");
    set_cfg(8'b11_111_101, 1'b0, 1'b0); align(); run(64, "R1");
    // R3: rate ignored in pulse mode
    set_cfg(8'b00_000_101, 1'b1, 1'b1); align(); run(64, "R3");
    // R5: double rate with N=1 floor and odd N
    set_cfg(8'b00_000_000, 1'b0, 1'b1); align(); run(64, "R5");
    set_cfg(8'b10_100_000, 1'b0, 1'b1); align(); run(64, "R5");
    // R6: mid-period change must not disturb the running period
    set_cfg(8'b01_000_011, 1'b1, 1'b0); align(); run(40, "R6");
    set_cfg(8'b11_000_000, 1'b0, 1'b1); run(10, "R6");
    set_cfg(8'b00_000_001, 1'b1, 1'b0); run(60, "R6");
    // R7: random settings with random change times
    for (int i = 0; i < 6400; i++) begin
      if ($urandom_range(0, 7) == 0)
        set_cfg(8'($urandom()), 1'($urandom()), 1'($urandom()));
      step("");
    end
    // R8: mid-run reset
    @(posedge clk); #3;
    do_reset();
    set_cfg(8'b00_000_010, 1'b1, 1'b0);
    run(96, "R8");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule